// File: doc/BRIEF.md
# Instruction Loader Sequencer

This block is the small controller between a byte-wide instruction prefetch queue and the execution control of a microcoded processor. It takes the opcode byte from the head of the queue and marks that cycle with a first-clock strobe. An external group-decode lookup reports a class code for that same byte. The sequencer then does one of four things. It can close a logic-only instruction with a second-clock strobe. It can treat a prefix byte the same way. It can pull a mode byte before it starts microcode. Or it can hand control straight to microcode.

The sequencer never works out how long an instruction is. While microcode runs, each queue-read request from the engine is passed through as a queue pop. A run-next request ends the instruction and sends the sequencer back to fetch the next opcode. Whenever a byte is needed and the queue is empty, the sequencer waits. A counter reports how many bytes the current instruction has used so far. It restarts at every first-clock strobe, so the length shows up only as a result.

Top module: `instr_loader`

## Requirements
- R1: After a synchronous reset, with the queue empty, the sequencer is waiting for an opcode. In that state `q_ready` is 1, `first_clk`, `second_clk` and `exec_active` are 0, and `byte_count`, `opcode` and `modrm` are 0.
- R2: In the opcode-wait state, `first_clk` is high in exactly the cycle in which an opcode byte is popped (`q_valid` and `q_ready` both high). The popped byte appears on `opcode` after that edge.
- R3: Class code 2'b01 (logic-only) makes `second_clk` high for one cycle in the cycle after the opcode pop. No byte is popped in that cycle, and the next opcode can be popped the cycle after, so the instruction takes two clocks.
- R4: Class code 2'b10 (prefix) behaves exactly like class 2'b01. Any number of prefixes in a row each count as one-byte, two-clock instructions.
- R5: Class code 2'b11 (mode byte) makes the sequencer pop one more byte, with `second_clk` high in that pop cycle. The byte appears on `modrm`, and `exec_active` goes high on the next cycle.
- R6: Class code 2'b00 (plain microcode) makes `exec_active` high from the cycle after the opcode pop. `second_clk` stays low.
- R7: While `exec_active` is high, `q_ready` equals `mc_qread`. Each cycle with `q_valid` and `mc_qread` both high pops one byte.
- R8: `mc_run_next` while `exec_active` is high returns the sequencer to the opcode-wait state on the next cycle. A pop requested in that same cycle is still taken.
- R9: When a byte is needed and `q_valid` is low, no pop happens, no strobe fires and the state is held until a byte arrives.
- R10: `byte_count` becomes 1 after each opcode pop and rises by one on every later pop of the same instruction. It saturates at 2^CNT_W-1 when SAT_COUNT=1 and wraps otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| q_valid | input | 1 | Queue head holds a byte |
| q_data | input | DATA_W | Byte at the queue head |
| q_ready | output | 1 | Sequencer takes the head byte this cycle if valid |
| grp_class | input | 2 | Group-decode class of the byte on `q_data` |
| mc_qread | input | 1 | Microcode asks for the next queue byte |
| mc_run_next | input | 1 | Microcode ends the current instruction |
| first_clk | output | 1 | Opcode byte taken this cycle |
| second_clk | output | 1 | Second-clock strobe |
| exec_active | output | 1 | Microcode owns the instruction |
| opcode | output | DATA_W | Last opcode byte taken |
| modrm | output | DATA_W | Last mode byte taken |
| byte_count | output | CNT_W | Bytes used by the current instruction |

## Verification
The bench drives long runs of prefixes to check that each one closes after two clocks. If a design held prefixes back, the run would stall. If it charged them as longer, the strobes would drift from the model. The bench also empties the queue in every state where a byte is wanted. A design that popped or strobed on an invalid head would fall out of step at once. Microcode runs are made long enough to reach counter saturation, which a wrapping counter fails. Run-next requests are issued in the same cycle as a queue read, to catch a design that drops that final pop.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
   typedef enum logic [1:0] {
      CLS_MICRO  = 2'b00,
      CLS_LOGIC  = 2'b01,
      CLS_PREFIX = 2'b10,
      CLS_MODRM  = 2'b11
   } grp_class_e;

   typedef enum logic [1:0] {
      ST_OPC   = 2'b00,
      ST_SC    = 2'b01,
      ST_MODRM = 2'b10,
      ST_EXEC  = 2'b11
   } ldr_state_e;
endpackage

// File: rtl/ldr_seq_fsm.sv
module ldr_seq_fsm
   import ldr_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       q_valid,
   input  logic [1:0] grp_class,
   input  logic       mc_qread,
   input  logic       mc_run_next,
   output logic       q_ready,
   output logic       pop,
   output logic       first_clk,
   output logic       second_clk,
   output logic       exec_active,
   output logic       modrm_take
);
   ldr_state_e state, state_nx;
   grp_class_e cls;

   assign cls = grp_class_e'(grp_class);

   always_comb begin
      q_ready = 1'b0;
      unique case (state)
         ST_OPC:   q_ready = 1'b1;
         ST_MODRM: q_ready = 1'b1;
         ST_EXEC:  q_ready = mc_qread;
         default:  q_ready = 1'b0;
      endcase
   end

   assign pop         = q_ready & q_valid;
   assign first_clk   = (state == ST_OPC) & q_valid;
   assign modrm_take  = (state == ST_MODRM) & q_valid;
   assign second_clk  = (state == ST_SC) | modrm_take;
   assign exec_active = (state == ST_EXEC);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_OPC: if (q_valid) begin
            unique case (cls)
               CLS_LOGIC, CLS_PREFIX: state_nx = ST_SC;
               CLS_MODRM:             state_nx = ST_MODRM;
               default:               state_nx = ST_EXEC;
            endcase
         end
         ST_SC:    state_nx = ST_OPC;
         ST_MODRM: if (q_valid) state_nx = ST_EXEC;
         default:  if (mc_run_next) state_nx = ST_OPC;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_OPC;
      else     state <= state_nx;
   end

   assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
      !(first_clk && second_clk));
   assert_logic_sc_follows_R3: assert property (@(posedge clk) disable iff (rst)
      (first_clk && (cls == CLS_LOGIC || cls == CLS_PREFIX)) |=> (second_clk && !q_ready));
   assert_modrm_to_exec_R5: assert property (@(posedge clk) disable iff (rst)
      modrm_take |=> exec_active);
   assert_micro_no_sc_R6: assert property (@(posedge clk) disable iff (rst)
      (first_clk && cls == CLS_MICRO) |=> (exec_active && !second_clk));
   assert_run_next_R8: assert property (@(posedge clk) disable iff (rst)
      (exec_active && mc_run_next) |=> (!exec_active && q_ready));
   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (state == ST_OPC && !q_valid) |=> (state == ST_OPC));
endmodule

// File: rtl/ldr_byte_counter.sv
module ldr_byte_counter #(
   parameter int CNT_W     = 4,
   parameter bit SAT_COUNT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             pop,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] inc;

   generate
      if (SAT_COUNT) begin : g_sat
         assign inc = (count == CNT_MAX) ? count : count + CNT_ONE;
      end else begin : g_wrap
         assign inc = count + CNT_ONE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)        count <= '0;
      else if (start) count <= CNT_ONE;
      else if (pop)   count <= inc;
   end

   assert_count_restart_R10: assert property (@(posedge clk) disable iff (rst)
      start |=> (count == CNT_ONE));
   assert_count_idle_R10: assert property (@(posedge clk) disable iff (rst)
      (!start && !pop) |=> $stable(count));
endmodule

// File: rtl/ldr_capture.sv
module ldr_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_en,
   input  logic              mr_en,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] opcode,
   output logic [DATA_W-1:0] modrm
);
   always_ff @(posedge clk) begin
      if (rst) begin
         opcode <= '0;
         modrm  <= '0;
      end else begin
         if (op_en) opcode <= din;
         if (mr_en) modrm  <= din;
      end
   end

   assert_opcode_capture_R2: assert property (@(posedge clk) disable iff (rst)
      op_en |=> (opcode == $past(din)));
   assert_modrm_capture_R5: assert property (@(posedge clk) disable iff (rst)
      mr_en |=> (modrm == $past(din)));
endmodule

// File: rtl/instr_loader.sv
module instr_loader #(
   parameter int DATA_W    = 8,
   parameter int CNT_W     = 4,
   parameter bit SAT_COUNT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              q_valid,
   input  logic [DATA_W-1:0] q_data,
   output logic              q_ready,
   input  logic [1:0]        grp_class,
   input  logic              mc_qread,
   input  logic              mc_run_next,
   output logic              first_clk,
   output logic              second_clk,
   output logic              exec_active,
   output logic [DATA_W-1:0] opcode,
   output logic [DATA_W-1:0] modrm,
   output logic [CNT_W-1:0]  byte_count
);
   if (DATA_W < 1) begin : g_bad_data_w
      $error("DATA_W must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("CNT_W must be at least 2");
   end

   logic pop, modrm_take;

   ldr_seq_fsm u_fsm (
      .clk(clk), .rst(rst), .q_valid(q_valid), .grp_class(grp_class),
      .mc_qread(mc_qread), .mc_run_next(mc_run_next), .q_ready(q_ready),
      .pop(pop), .first_clk(first_clk), .second_clk(second_clk),
      .exec_active(exec_active), .modrm_take(modrm_take)
   );

   ldr_byte_counter #(.CNT_W(CNT_W), .SAT_COUNT(SAT_COUNT)) u_cnt (
      .clk(clk), .rst(rst), .start(first_clk), .pop(pop), .count(byte_count)
   );

   ldr_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst(rst), .op_en(first_clk), .mr_en(modrm_take),
      .din(q_data), .opcode(opcode), .modrm(modrm)
   );

   assert_exec_ready_R7: assert property (@(posedge clk) disable iff (rst)
      exec_active |-> (q_ready == mc_qread));
   assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (rst)
      !q_valid |-> !(first_clk || (second_clk && !$past(first_clk))));
endmodule

// File: tb/test_instr_loader.sv
module test_instr_loader;
   localparam int DW = 8;
   localparam int CW = 4;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic q_valid = 1'b0;
   logic [DW-1:0] q_data = '0;
   logic [1:0] grp_class = 2'b00;
   logic mc_qread = 1'b0;
   logic mc_run_next = 1'b0;
   logic q_ready, first_clk, second_clk, exec_active;
   logic [DW-1:0] opcode, modrm;
   logic [CW-1:0] byte_count;

   always #10 clk = ~clk;

   instr_loader #(.DATA_W(DW), .CNT_W(CW), .SAT_COUNT(1'b1)) i_instr_loader (
      .clk(clk), .rst(rst), .q_valid(q_valid), .q_data(q_data), .q_ready(q_ready),
      .grp_class(grp_class), .mc_qread(mc_qread), .mc_run_next(mc_run_next),
      .first_clk(first_clk), .second_clk(second_clk), .exec_active(exec_active),
      .opcode(opcode), .modrm(modrm), .byte_count(byte_count)
   );

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference model state: 0 opcode wait, 1 second clock, 2 mode byte, 3 microcode
   int m_st = 0;
   int m_cnt = 0;
   int m_op = 0;
   int m_mr = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   // one cycle: drive at negedge, compare, then advance the model at the edge
   task automatic step(input int pv, input int pq, input int pr, input int force_cls);
      bit v, qr, rn;
      int cls;
      bit e_fc, e_sc, e_ex, e_rdy, e_pop;
      @(negedge clk);
      v  = ($urandom_range(99) < pv);
      qr = ($urandom_range(99) < pq);
      rn = ($urandom_range(99) < pr);
      cls = (force_cls >= 0) ? force_cls : int'($urandom_range(3));
      q_valid = v;
      q_data = DW'($urandom);
      grp_class = 2'(cls);
      mc_qread = qr;
      mc_run_next = rn;
      #2;
      e_rdy = (m_st == 0) || (m_st == 2) || (m_st == 3 && qr);
      e_pop = e_rdy && v;
      e_fc  = (m_st == 0) && v;
      e_sc  = (m_st == 1) || (m_st == 2 && v);
      e_ex  = (m_st == 3);
      chk("R2", "first_clk", int'(first_clk), int'(e_fc));
      chk(cls == 2 ? "R4" : "R3", "second_clk", int'(second_clk), int'(e_sc));
      chk("R6", "exec_active", int'(exec_active), int'(e_ex));
      chk(v ? "R7" : "R9", "q_ready", int'(q_ready), int'(e_rdy));
      chk("R10", "byte_count", int'(byte_count), m_cnt);
      chk("R2", "opcode", int'(opcode), m_op);
      chk("R5", "modrm", int'(modrm), m_mr);
      if (e_fc) begin
         m_cnt = 1;
         m_op = int'(q_data);
      end else if (e_pop) begin
         m_cnt = (m_cnt < CMAX) ? m_cnt + 1 : CMAX;
      end
      if (m_st == 2 && v) m_mr = int'(q_data);
      case (m_st)
         0: if (v) m_st = (cls == 1 || cls == 2) ? 1 : (cls == 3) ? 2 : 3;
         1: m_st = 0;
         2: if (v) m_st = 3;
         default: if (rn) m_st = 0;
      endcase
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #2;
      // R1 reset state
      chk("R1", "q_ready", int'(q_ready), 1);
      chk("R1", "first_clk", int'(first_clk), 0);
      chk("R1", "second_clk", int'(second_clk), 0);
      chk("R1", "exec_active", int'(exec_active), 0);
      chk("R1", "byte_count", int'(byte_count), 0);
      chk("R1", "opcode", int'(opcode), 0);
      // R4 long prefix chain, full queue
      for (int i = 0; i < 40; i++) step(100, 0, 0, 2);
      // R3 logic-only instructions with a sparse queue (R9 stalls)
      for (int i = 0; i < 60; i++) step(40, 0, 0, 1);
      // R5 mode-byte instructions, R8 run-next
      for (int i = 0; i < 300; i++) step(70, 50, 20, 3);
      // R6 plain microcode, long runs to reach counter saturation (R10)
      for (int i = 0; i < 400; i++) step(95, 95, 2, 0);
      // R7/R8 mixed classes, run-next with reads in the same cycle
      for (int i = 0; i < 4000; i++) step(75, 60, 25, -1);
      // R9 empty queue everywhere
      for (int i = 0; i < 200; i++) step(10, 50, 30, -1);
      summary();
   end

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end
endmodule